// File: doc/BRIEF.md
# Test-Mode Register and Block Write-Enable Generator

This block sits between the serial command decoder and the timed programming controller of a small byte-wide non-volatile array. It holds the current array address and a test byte. A program command aimed at array rows turns into a write-enable vector with one bit per row. The programming controller then runs one timed cycle on every row that has its enable bit set.

The test byte is written by loading test address 516 and then issuing a program command. It lasts until the next such write or until reset clears it. With the master test enable bit and the block bit both set, one program command writes several rows in the same cycle. Address bits 1 and 0 select the set of rows: every row, only the even rows, or only the odd rows. A checkerboard therefore takes two commands. Guarded rows still need the safe input high. The test byte also drives a charge-pump disable flag and a read-reference trim code for the analog side.

Top module: `tmode_blkwr_gen`

## Requirements
- R1: While reset is low and on the first cycle after it, row_we, wr_start, wr_data, cur_addr, tbyte, pump_off and ref_trim are all zero.
- R2: An address load with busy_in low sets cur_addr to addr_in from the next cycle on. With busy_in high the load is ignored.
- R3: A program command with busy_in low while cur_addr is 516 stores prog_data into tbyte from the next cycle on and raises no row_we bit.
- R4: A program command with busy_in high changes neither tbyte nor row_we. row_we stays zero in the cycle after it.
- R5: When block mode is not active, a program command with busy_in low and cur_addr below 512 raises exactly bit cur_addr of row_we, one cycle later, with wr_data equal to prog_data (guard rule R9 still applies).
- R6: Block mode is active only when tbyte bit 5 (test enable) and bit 7 (block) are both 1. Value 0x80 alone gives a single-row write.
- R7: In block mode with cur_addr bit 1 equal to 0, the command enables every row.
- R8: In block mode with cur_addr bit 1 equal to 1, the command enables exactly the rows whose bit 0 equals cur_addr bit 0. For example, 85 at address 2 and then 170 at address 3 builds a checkerboard.
- R9: A row whose index modulo 64 is below 16 is guarded. Its row_we bit is raised only when safe_in was 1 in the command's cycle.
- R10: pump_off equals tbyte bit 5 AND bit 3. ref_trim is {bit6, bit4, bit2, bit1, bit0} of tbyte when bit 5 is 1, and zero otherwise.
- R11: A program command with busy_in low and cur_addr at 512 or above, other than 516, raises no row_we bit and leaves tbyte unchanged.
- R12: row_we lasts one cycle per accepted command. wr_start is 1 exactly in cycles where row_we is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the test byte |
| addr_ld | input | 1 | Address load command, one cycle |
| addr_in | input | 10 | Address carried by the load command |
| busy_in | input | 1 | Programming cycle in progress |
| prog_req | input | 1 | Program command, one cycle |
| prog_data | input | 8 | Data carried by the program command |
| safe_in | input | 1 | Allows writes to guarded rows |
| row_we | output | 512 | Per-row write enable, one-cycle pulse |
| wr_data | output | 8 | Data for the enabled rows |
| wr_start | output | 1 | Start of a timed programming cycle |
| cur_addr | output | 10 | Currently loaded address |
| tbyte | output | 8 | Test byte contents |
| pump_off | output | 1 | Charge-pump disable flag |
| ref_trim | output | 5 | Read-reference trim code |

## Verification
Some rules are checked by assertions on every cycle. While busy, the test byte and address hold still, and no enable comes out of a refused command. The test byte only changes after an accepted write to address 516. No guarded row is enabled without safe_in. A write outside block mode enables a single row. The pump flag follows its two bits. Other behaviours need whole-vector comparison, so only the bench's scenarios show them: the exact row set of a block write (all, even, odd), the checkerboard pair, the 0x80-without-enable case, and commands to out-of-array addresses.

// File: rtl/tmb_pkg.sv
package tmb_pkg;
  localparam int DATA_W   = 8;
  localparam int EN_BIT   = 5;
  localparam int BLK_BIT  = 7;
  localparam int PUMP_BIT = 3;

  typedef logic [DATA_W-1:0] tbyte_t;

  // Guarded rows: the first span rows of every period.
  function automatic logic in_guard(input int unsigned row,
                                    input int unsigned period,
                                    input int unsigned span);
    return (row % period) < span;
  endfunction

  // Block selection: a1 = 0 picks every row, else rows of parity a0.
  function automatic logic blk_pick(input int unsigned row,
                                    input logic a1, input logic a0);
    return (!a1) || (logic'(row % 2) == a0);
  endfunction

  function automatic logic [4:0] trim_of(input tbyte_t tb);
    return tb[EN_BIT] ? {tb[6], tb[4], tb[2], tb[1], tb[0]} : 5'd0;
  endfunction
endpackage

// File: rtl/tmb_addr_reg.sv
module tmb_addr_reg #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic              busy,
  input  logic [ADDR_W-1:0] din,
  output logic [ADDR_W-1:0] q
);
  logic take;
  assign take = ld & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (take) q <= din;
  end
endmodule

// File: rtl/tmb_test_reg.sv
module tmb_test_reg
  import tmb_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int TEST_ADDR = 516
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_req,
  input  logic              busy,
  input  logic [ADDR_W-1:0] cur_addr,
  input  tbyte_t            din,
  output tbyte_t            tbyte_q,
  output logic              tb_wr,
  output logic              blk_active,
  output logic              pump_off,
  output logic [4:0]        ref_trim
);
  localparam logic [ADDR_W-1:0] TEST_A = ADDR_W'(TEST_ADDR);

  assign tb_wr = prog_req & ~busy & (cur_addr == TEST_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tbyte_q <= '0;
    else if (tb_wr) tbyte_q <= din;
  end

  assign blk_active = tbyte_q[EN_BIT] & tbyte_q[BLK_BIT];
  assign pump_off   = tbyte_q[EN_BIT] & tbyte_q[PUMP_BIT];
  assign ref_trim   = trim_of(tbyte_q);
endmodule

// File: rtl/tmb_we_gen.sv
module tmb_we_gen
  import tmb_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DEPTH       = 512,
  parameter int PROT_PERIOD = 64,
  parameter int PROT_SPAN   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic              blk_use,
  input  logic              safe,
  input  tbyte_t            din,
  output logic [DEPTH-1:0]  row_we,
  output tbyte_t            wr_data,
  output logic              wr_start
);
  logic [DEPTH-1:0] we_next;
  logic [DEPTH-1:0] sel_vec;

  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    localparam logic GUARD = in_guard(r, PROT_PERIOD, PROT_SPAN);
    always_comb begin
      sel_vec[r] = blk_use ? blk_pick(r, addr[1], addr[0])
                           : (addr == ADDR_W'(r));
      we_next[r] = fire & sel_vec[r] & (~GUARD | safe);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_we   <= '0;
      wr_data  <= '0;
      wr_start <= 1'b0;
    end else begin
      row_we   <= we_next;
      wr_start <= |we_next;
      if (fire) wr_data <= din;
    end
  end
endmodule

// File: rtl/tmode_blkwr_gen.sv
module tmode_blkwr_gen
  import tmb_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DEPTH       = 512,
  parameter int TEST_ADDR   = 516,
  parameter int PROT_PERIOD = 64,
  parameter int PROT_SPAN   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_ld,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              busy_in,
  input  logic              prog_req,
  input  logic [DATA_W-1:0] prog_data,
  input  logic              safe_in,
  output logic [DEPTH-1:0]  row_we,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_start,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] tbyte,
  output logic              pump_off,
  output logic [4:0]        ref_trim
);
  localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(DEPTH);

  logic prog_ok;
  logic arr_hit;
  logic fire;
  logic tb_wr;
  logic blk_active;
  logic blk_use;

  tmb_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .ld(addr_ld), .busy(busy_in),
    .din(addr_in), .q(cur_addr)
  );

  tmb_test_reg #(.ADDR_W(ADDR_W), .TEST_ADDR(TEST_ADDR)) u_treg (
    .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .busy(busy_in),
    .cur_addr(cur_addr), .din(prog_data), .tbyte_q(tbyte),
    .tb_wr(tb_wr), .blk_active(blk_active), .pump_off(pump_off),
    .ref_trim(ref_trim)
  );

  assign prog_ok = prog_req & ~busy_in;
  assign arr_hit = cur_addr < DEPTH_A;
  assign fire    = prog_ok & arr_hit;
  assign blk_use = blk_active & ~cur_addr[ADDR_W-1];

  tmb_we_gen #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH),
    .PROT_PERIOD(PROT_PERIOD), .PROT_SPAN(PROT_SPAN)
  ) u_we (
    .clk(clk), .rst_n(rst_n), .fire(fire), .addr(cur_addr),
    .blk_use(blk_use), .safe(safe_in), .din(prog_data),
    .row_we(row_we), .wr_data(wr_data), .wr_start(wr_start)
  );
endmodule

// File: rtl/tmb_chk.sv
module tmb_chk
  import tmb_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DEPTH       = 512,
  parameter int TEST_ADDR   = 516,
  parameter int PROT_PERIOD = 64,
  parameter int PROT_SPAN   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prog_req,
  input logic              busy_in,
  input logic              safe_in,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [DEPTH-1:0]  row_we,
  input logic [DATA_W-1:0] tbyte,
  input logic              pump_off,
  input logic              blk_use
);
  localparam logic [ADDR_W-1:0] TEST_A = ADDR_W'(TEST_ADDR);

  logic [DEPTH-1:0] guard_m;
  for (genvar r = 0; r < DEPTH; r++) begin : g_gm
    assign guard_m[r] = in_guard(r, PROT_PERIOD, PROT_SPAN);
  end

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_in |=> $stable(cur_addr));

  p_tb_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tbyte) |-> $past(prog_req && !busy_in && cur_addr == TEST_A));

  p_tb_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_in |=> $stable(tbyte));

  p_no_we_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_in |=> (row_we == '0));

  p_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (row_we != '0) && !$past(blk_use) |-> $countones(row_we) == 1);

  p_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((row_we & guard_m) != '0) |-> $past(safe_in));

  p_pump_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pump_off |-> (tbyte[EN_BIT] && tbyte[PUMP_BIT]));
endmodule

bind tmode_blkwr_gen tmb_chk #(
  .ADDR_W(ADDR_W), .DEPTH(DEPTH), .TEST_ADDR(TEST_ADDR),
  .PROT_PERIOD(PROT_PERIOD), .PROT_SPAN(PROT_SPAN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .busy_in(busy_in),
  .safe_in(safe_in), .cur_addr(cur_addr), .row_we(row_we),
  .tbyte(tbyte), .pump_off(pump_off), .blk_use(blk_use)
);

// File: tb/sim_tmode_blkwr_gen.sv
module sim_tmode_blkwr_gen;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         addr_ld, prog_req, busy_in, safe_in;
  logic [9:0]   addr_in;
  logic [7:0]   prog_data;
  logic [511:0] row_we;
  logic [7:0]   wr_data, tbyte;
  logic         wr_start, pump_off;
  logic [9:0]   cur_addr;
  logic [4:0]   ref_trim;

  int n_cmp = 0;
  int n_bad = 0;
  logic [9:0] m_addr = '0;
  logic [7:0] m_tb   = '0;

  always #4 clk = ~clk;

  tmode_blkwr_gen u0 (
    .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_in(addr_in),
    .busy_in(busy_in), .prog_req(prog_req), .prog_data(prog_data),
    .safe_in(safe_in), .row_we(row_we), .wr_data(wr_data),
    .wr_start(wr_start), .cur_addr(cur_addr), .tbyte(tbyte),
    .pump_off(pump_off), .ref_trim(ref_trim)
  );

  task automatic chk(input string req, input string what,
                     input logic [511:0] got, input logic [511:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  // Rows enabled by one accepted command at array address a.
  function automatic logic [511:0] model_we(input logic [9:0] a,
                                            input logic [7:0] tb,
                                            input bit sf);
    logic [511:0] v = '0;
    bit blk = (tb[5] == 1'b1) && (tb[7] == 1'b1);
    for (int r = 0; r < 512; r++) begin
      bit pick, locked;
      if (blk) pick = (a[1] == 1'b0) || ((r % 2) == int'(a[0]));
      else     pick = (r == int'(a));
      locked = (r % 64) < 16 && !sf;
      v[r] = pick && !locked;
    end
    return v;
  endfunction

  function automatic logic [4:0] model_trim(input logic [7:0] tb);
    if (!tb[5]) return 5'd0;
    return {tb[6], tb[4], tb[2], tb[1], tb[0]};
  endfunction

  task automatic check_state(input string tag);
    chk("R2", {tag, " cur_addr"}, 512'(cur_addr), 512'(m_addr));
    chk("R3", {tag, " tbyte"}, 512'(tbyte), 512'(m_tb));
    chk("R10", {tag, " pump_off"}, 512'(pump_off), 512'(m_tb[5] & m_tb[3]));
    chk("R10", {tag, " ref_trim"}, 512'(ref_trim), 512'(model_trim(m_tb)));
  endtask

  task automatic op(input string tag, input bit is_ld, input bit is_pg,
                    input logic [9:0] a, input logic [7:0] d,
                    input bit bsy, input bit sf);
    logic [511:0] exp_we = '0;
    @(negedge clk);
    addr_ld = is_ld; addr_in = a; prog_req = is_pg; prog_data = d;
    busy_in = bsy; safe_in = sf;
    if (is_pg && !bsy && m_addr < 10'd512) exp_we = model_we(m_addr, m_tb, sf);
    @(negedge clk);
    addr_ld = 1'b0; prog_req = 1'b0; busy_in = 1'b0;
    if (is_pg && !bsy && m_addr == 10'd516) m_tb = d;
    if (is_ld && !bsy) m_addr = a;
    chk(tag, "row_we", row_we, exp_we);
    chk("R12", {tag, " wr_start"}, 512'(wr_start), 512'(exp_we != '0));
    if (exp_we != '0) chk("R5", {tag, " wr_data"}, 512'(wr_data), 512'(d));
    check_state(tag);
  endtask

  task automatic idle_pulse_check(input string tag);
    @(negedge clk);
    chk("R12", {tag, " pulse ends"}, row_we, '0);
    chk("R12", {tag, " start ends"}, 512'(wr_start), '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250917));
    rst_n = 1'b0; addr_ld = 0; prog_req = 0; busy_in = 0; safe_in = 0;
    addr_in = '0; prog_data = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset row_we", row_we, '0);
    chk("R1", "reset wr_data", 512'(wr_data), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "post-reset wr_start", 512'(wr_start), '0);
    check_state("R1");

    // R5 single write, guarded row R9 with and without safe
    op("R5", 1, 0, 10'd100, 8'h00, 0, 0);
    op("R5", 0, 1, 10'd0, 8'h3C, 0, 0);
    idle_pulse_check("R12");
    op("R9", 1, 0, 10'd70, 8'h00, 0, 0);
    op("R9", 0, 1, 10'd0, 8'h11, 0, 0);
    op("R9", 0, 1, 10'd0, 8'h22, 0, 1);
    // R2 load refused while busy
    op("R2", 1, 0, 10'd300, 8'h00, 1, 0);
    // R6 block bit without test enable
    op("R3", 1, 0, 10'd516, 8'h00, 0, 0);
    op("R6", 0, 1, 10'd0, 8'h80, 0, 0);
    op("R6", 1, 0, 10'd5, 8'h00, 0, 1);
    op("R6", 0, 1, 10'd0, 8'h5A, 0, 1);
    // R4 test byte write refused while busy
    op("R3", 1, 0, 10'd516, 8'h00, 0, 0);
    op("R4", 0, 1, 10'd0, 8'hA0, 1, 0);
    // R3 enable block mode (160)
    op("R3", 0, 1, 10'd0, 8'hA0, 0, 0);
    // R7 all rows, unsafe then safe
    op("R7", 1, 0, 10'd4, 8'h00, 0, 0);
    op("R7", 0, 1, 10'd0, 8'h77, 0, 0);
    op("R7", 0, 1, 10'd0, 8'h78, 0, 1);
    // R8 checkerboard: 85 at 2, 170 at 3
    op("R8", 1, 0, 10'd2, 8'h00, 0, 1);
    op("R8", 0, 1, 10'd0, 8'd85, 0, 1);
    chk("R8", "even count", 512'($countones(row_we)), 512'(256));
    op("R8", 1, 0, 10'd3, 8'h00, 0, 1);
    op("R8", 0, 1, 10'd0, 8'd170, 0, 1);
    chk("R8", "odd count", 512'($countones(row_we)), 512'(256));
    // R11 out-of-array address
    op("R11", 1, 0, 10'd526, 8'h00, 0, 1);
    op("R11", 0, 1, 10'd0, 8'hFF, 0, 1);
    // R10 pump and trim bits
    op("R10", 1, 0, 10'd516, 8'h00, 0, 0);
    op("R10", 0, 1, 10'd0, 8'h7F, 0, 0);
    op("R10", 0, 1, 10'd0, 8'h5F, 0, 0);

    for (int i = 0; i < 400; i++) begin
      int k = $urandom_range(0, 9);
      bit bsy = ($urandom_range(0, 4) == 0);
      bit sf  = 1'($urandom_range(0, 1));
      logic [9:0] a;
      logic [7:0] d;
      case ($urandom_range(0, 3))
        0: a = 10'd516;
        1: a = 10'(512 + $urandom_range(0, 511));
        2: a = 10'($urandom_range(0, 3));
        default: a = 10'($urandom_range(0, 511));
      endcase
      if (m_addr == 10'd516)
        case ($urandom_range(0, 4))
          0: d = 8'hA0;
          1: d = 8'hA8;
          2: d = 8'h80;
          3: d = 8'h00;
          default: d = 8'($urandom_range(0, 255));
        endcase
      else d = 8'($urandom_range(0, 255));
      if (k < 4)      op("R2", 1, 0, a, d, bsy, sf);
      else if (k < 9) op("R5/R7/R8/R9/R11", 0, 1, a, d, bsy, sf);
      else            op("R12", 0, 0, a, d, bsy, sf);
    end

    // reset mid-run clears the test byte (R1)
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_tb = '0; m_addr = '0;
    @(negedge clk);
    check_state("R1");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule